// File: doc/BRIEF.md
# Timer-Based Pulse-Width Modulator with Sub-Tick Duty Resolution

The block produces one pulse-width-modulated output from a free-running count. A selectable prescaler (divide by 1, 4 or 16) slows a 10-bit extended count. The upper 8 bits of that count act as the timer. The lower 2 bits are a phase that resolves a quarter of one timer tick. A programmable period value ends the cycle early: after the timer reaches the period value and the phase reaches its last step, the count returns to zero. One output period is therefore 4·(period+1)·prescale clock cycles.

The output goes high at each period start. It goes low once the extended count reaches the 10-bit duty value, which is formed as 4·coarse + fine. A duty value of 0 keeps the output low. A duty value that is not smaller than the period length keeps the output high for the whole period; it does not wrap. Duty and period writes go first into shadow registers. They are copied into the active registers only at a period boundary, or at once while the generator is stopped. Software configures the block through a small byte-wide write port. A one-cycle strobe marks the first cycle of every period.

Top module: `pwm_timer_gen`

## Requirements
- R1: After reset, pwm_o and restart_o are 0, and both remain 0 until the generator is started.
- R2: While running, restart_o pulses for one cycle at the start of each period. Consecutive pulses are exactly 4·(period+1)·P clock cycles apart, where period is register address 0 and P is the prescale factor.
- R3: The prescale select is bits [1:0] of address 3. Its encoding is 0 → P=1, 1 → P=4, 2 or 3 → P=16. The timer-on bit is bit 2 of the same address.
- R4: Per period, pwm_o is high for exactly min(D, 4·(period+1))·P cycles, starting in the cycle that restart_o is high. D = 4·coarse + fine, where coarse is address 1 and fine is bits [5:4] of address 2.
- R5: With D = 0, pwm_o stays low for the whole period.
- R6: With D ≥ 4·(period+1), pwm_o stays high for the whole period.
- R7: A write to the duty or period registers made during a period does not change that period. It takes effect from the next period start.
- R8: The generator runs only when the mode field, bits [3:0] of address 2, equals 4'b1100 and the timer-on bit is 1. Otherwise pwm_o and restart_o stay 0.
- R9: pwm_o rises only in a cycle in which restart_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (base count clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 period, 1 coarse duty, 2 mode and fine duty, 3 timer control) |
| wr_data_i | input | 8 | Register write data |
| pwm_o | output | 1 | Modulated output |
| restart_o | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The assertions assume that the register port changes the run condition at most once per write. This ensures that two period-start strobes can never come in adjacent cycles. They also assume that the active duty and period values change only when the generator is stopped or at a boundary. The stimulus respects both assumptions. Full reconfiguration happens with the timer switched off. Mid-period writes are made only to the shadowed duty and period registers. The sweeps cover every duty value from zero to one past saturation, for small periods and all three prescale factors.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [3:0] MODE_PWM = 4'b1100;

  typedef enum logic [1:0] {
    ADDR_PERIOD  = 2'd0,
    ADDR_DUTY_HI = 2'd1,
    ADDR_MODE    = 2'd2,
    ADDR_TIMER   = 2'd3
  } reg_addr_e;

  localparam int unsigned PSC_W = 4;

  function automatic logic [PSC_W-1:0] psc_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    return PSC_W'(0);
      2'd1:    return PSC_W'(3);
      default: return PSC_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  period_sh_o,
  output logic [DUTY_W-1:0] duty_sh_o,
  output logic [1:0]        psc_sel_o,
  output logic              run_o
);
  logic [CNT_W-1:0]  period_q;
  logic [CNT_W-1:0]  duty_hi_q;
  logic [FRAC_W-1:0] duty_lo_q;
  logic [3:0]        mode_q;
  logic              tmr_on_q;
  logic [1:0]        psc_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q  <= '0;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      mode_q    <= '0;
      tmr_on_q  <= 1'b0;
      psc_sel_q <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        ADDR_PERIOD:  period_q  <= wr_data_i;
        ADDR_DUTY_HI: duty_hi_q <= wr_data_i;
        ADDR_MODE: begin
          mode_q    <= wr_data_i[3:0];
          duty_lo_q <= wr_data_i[4 +: FRAC_W];
        end
        ADDR_TIMER: begin
          psc_sel_q <= wr_data_i[1:0];
          tmr_on_q  <= wr_data_i[2];
        end
        default: ;
      endcase
    end
  end

  assign period_sh_o = period_q;
  assign duty_sh_o   = {duty_hi_q, duty_lo_q};
  assign psc_sel_o   = psc_sel_q;
  assign run_o       = tmr_on_q && (mode_q == MODE_PWM);
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] psc_sel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic             hit;

  // >= so a shrinking divider never runs past its limit
  assign hit    = cnt_q >= psc_limit(psc_sel_i);
  assign tick_o = run_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (hit)     cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  period_sh_i,
  output logic [CNT_W-1:0]  period_act_o,
  output logic [DUTY_W-1:0] ext_cnt_o,
  output logic              wrap_o
);
  logic [DUTY_W-1:0] ext_q;
  logic [CNT_W-1:0]  per_q;
  logic              at_end;

  assign at_end = ext_q == {per_q, {FRAC_W{1'b1}}};
  assign wrap_o = run_i && tick_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= '0;
      per_q <= '0;
    end else if (!run_i) begin
      ext_q <= '0;
      per_q <= period_sh_i;
    end else if (tick_i) begin
      if (at_end) begin
        ext_q <= '0;
        per_q <= period_sh_i;
      end else begin
        ext_q <= ext_q + 1'b1;
      end
    end
  end

  assign period_act_o = per_q;
  assign ext_cnt_o    = ext_q;
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wrap_i,
  input  logic [DUTY_W-1:0] duty_sh_i,
  input  logic [DUTY_W-1:0] ext_cnt_i,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic              pwm_o,
  output logic              restart_o
);
  logic [DUTY_W-1:0] duty_q;
  logic              run_d_q;
  logic              wrap_d_q;
  logic              pwm_q;
  logic              restart_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q    <= '0;
      run_d_q   <= 1'b0;
      wrap_d_q  <= 1'b0;
      pwm_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      if (!run_i || wrap_i) duty_q <= duty_sh_i;
      run_d_q   <= run_i;
      wrap_d_q  <= wrap_i;
      // count never exceeds 4*(period+1)-1, so large duty saturates high
      pwm_q     <= run_i && (ext_cnt_i < duty_q);
      restart_q <= run_i && (wrap_d_q || !run_d_q);
    end
  end

  assign duty_act_o = duty_q;
  assign pwm_o      = pwm_q;
  assign restart_o  = restart_q;
endmodule

// File: rtl/pwm_timer_gen.sv
module pwm_timer_gen #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned DUTY_W = CNT_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             restart_o
);
  logic [CNT_W-1:0]  period_sh;
  logic [CNT_W-1:0]  period_act;
  logic [DUTY_W-1:0] duty_sh;
  logic [DUTY_W-1:0] duty_act;
  logic [DUTY_W-1:0] ext_cnt;
  logic [1:0]        psc_sel;
  logic              run;
  logic              tick;
  logic              wrap;

  pwm_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_sh_o(period_sh), .duty_sh_o(duty_sh),
    .psc_sel_o(psc_sel), .run_o(run)
  );

  pwm_prescaler i_psc (
    .clk_i, .rst_ni, .run_i(run), .psc_sel_i(psc_sel), .tick_o(tick)
  );

  pwm_timebase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_tb (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick),
    .period_sh_i(period_sh), .period_act_o(period_act),
    .ext_cnt_o(ext_cnt), .wrap_o(wrap)
  );

  pwm_duty_cmp #(.DUTY_W(DUTY_W)) i_cmp (
    .clk_i, .rst_ni, .run_i(run), .wrap_i(wrap),
    .duty_sh_i(duty_sh), .ext_cnt_i(ext_cnt),
    .duty_act_o(duty_act), .pwm_o, .restart_o
  );
endmodule

// File: rtl/pwm_timer_gen_chk.sv
module pwm_timer_gen_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned DUTY_W = CNT_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwm_o,
  input logic              restart_o,
  input logic              run,
  input logic [DUTY_W-1:0] duty_act,
  input logic [CNT_W-1:0]  period_act
);
  logic [DUTY_W:0] len;
  logic            sat;
  assign len = ({1'b0, period_act, {FRAC_W{1'b0}}}) + (DUTY_W+1)'(1 << FRAC_W);
  assign sat = {1'b0, duty_act} >= len;

  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);
  a_r9_rise_at_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> restart_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!run) |-> (!pwm_o && !restart_o));
  a_r5_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run && duty_act == '0) |-> !pwm_o);
  a_r6_saturate_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run && sat) |-> pwm_o);
endmodule

bind pwm_timer_gen pwm_timer_gen_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_o(pwm_o), .restart_o(restart_o),
  .run(run), .duty_act(duty_act), .period_act(period_act)
);

// File: tb/test_pwm_timer_gen.sv
`timescale 1ns/1ps
module test_pwm_timer_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm;
  logic       restart;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pwm_timer_gen i_pwm_timer_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .restart_o(restart)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int pfac(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
  endfunction

  // timer off, load everything, then start
  task automatic config_run(input int per, input int duty, input int sel);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'(per));
    wr(2'd1, 8'(duty >> 2));
    wr(2'd2, {2'b00, 2'(duty & 3), 4'b1100});
    wr(2'd3, {5'b0, 1'b1, 2'(sel)});
  endtask

  task automatic measure(output int hi, output int len);
    while (!restart) @(negedge clk);
    hi = 0; len = 0;
    do begin
      hi += int'(pwm); len++;
      @(negedge clk);
    end while (!restart);
  endtask

  task automatic expect_period(input int per, input int duty, input int sel, input string tag);
    int hi, len, p, full;
    p = pfac(sel);
    full = 4 * (per + 1);
    measure(hi, len);
    check(len == full * p, {tag, " R2 R3 period"}, len, full * p);
    check(hi == ((duty < full) ? duty : full) * p, {tag, " R4 high"}, hi, ((duty < full) ? duty : full) * p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    int hi, len, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(pwm == 1'b0, "R1 pwm after reset", int'(pwm), 0);
    check(restart == 1'b0, "R1 restart after reset", int'(restart), 0);
    bad = 0;
    repeat (40) begin @(negedge clk); bad += int'(pwm) + int'(restart); end
    check(bad == 0, "R1 idle before start", bad, 0);

    // near-exhaustive sweep: R2 R3 R4 R5 R6
    foreach (pfac_list[i]) ;
    for (int sel = 0; sel < 4; sel++) begin
      int pers[3] = '{0, 1, 3};
      foreach (pers[k]) begin
        for (int d = 0; d <= 4 * (pers[k] + 1) + 1; d++) begin
          config_run(pers[k], d, sel);
          expect_period(pers[k], d, sel, "sweep");
        end
      end
    end

    // R4 50 percent: period 249, coarse 125, P=4
    config_run(249, 500, 1);
    expect_period(249, 500, 1, "half");
    // R4 fractional: period 208, coarse 137, fine 3
    config_run(208, 137 * 4 + 3, 0);
    expect_period(208, 551, 0, "frac");
    expect_period(208, 551, 0, "frac2");
    // R6 saturated: coarse 209 above period 208
    config_run(208, 209 * 4 + 3, 0);
    expect_period(208, 839, 0, "sat R6");
    // R5 zero duty on a long period
    config_run(20, 0, 1);
    expect_period(20, 0, 1, "zero R5");

    // R7: mid-period writes deferred to next start
    config_run(3, 5, 0);
    while (!restart) @(negedge clk);
    hi = 0; len = 0;
    do begin
      case (len)
        2: begin wr_addr = 2'd0; wr_data = 8'd1; wr_en = 1'b1; end
        3: begin wr_addr = 2'd1; wr_data = 8'd2; wr_en = 1'b1; end
        4: begin wr_addr = 2'd2; wr_data = 8'b0010_1100; wr_en = 1'b1; end
        default: wr_en = 1'b0;
      endcase
      hi += int'(pwm); len++;
      @(negedge clk);
    end while (!restart);
    wr_en = 1'b0;
    check(len == 16, "R7 old period kept", len, 16);
    check(hi == 5, "R7 old duty kept", hi, 5);
    expect_period(1, 10, 0, "R7 new");

    // R8: wrong mode with timer on
    config_run(3, 8, 0);
    wr(2'd2, 8'b0000_0101);
    @(negedge clk);
    bad = 0;
    repeat (100) begin bad += int'(pwm) + int'(restart); @(negedge clk); end
    check(bad == 0, "R8 wrong mode silent", bad, 0);
    // R8: right mode, timer off
    config_run(3, 8, 0);
    wr(2'd3, 8'h01);
    @(negedge clk);
    bad = 0;
    repeat (100) begin bad += int'(pwm) + int'(restart); @(negedge clk); end
    check(bad == 0, "R8 timer off silent", bad, 0);

    // R9: every rising edge of pwm coincides with restart
    config_run(2, 7, 1);
    bad = 0;
    begin
      logic prev;
      prev = pwm;
      repeat (300) begin
        @(negedge clk);
        if (pwm && !prev && !restart) bad++;
        prev = pwm;
      end
    end
    check(bad == 0, "R9 rise only at restart", bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  int pfac_list[1] = '{0};
endmodule